// File: doc/BRIEF.md
# Selector Channel DMA Controller

This block is a single-channel, byte-serial DMA engine that a processor programs through a byte-wide I/O port. The port has four strobes. A command write starts or halts the channel. A data write shifts one address byte into the channel. A data read returns one byte of the current start address. A status read reports whether the channel is busy, or else returns a status byte.

The start and end addresses share one shift path. Each data write pushes the new byte into the end register, and the byte that leaves the end register moves into the start register. How many bytes are accepted depends on the addressing mode, which is a static input: plain 16-bit, 18-bit banked (the bank comes from the command), or 20-bit extended.

Once started, the channel waits for the attached device to request a byte. For each request it performs one memory beat at the current start address, either memory to device or device to memory. When the final address has been moved, it raises an interrupt and stops. While it runs, a blocking flag tells the rest of the system that the processor must not talk to the device directly.

Top module: `selch_dma`

## Requirements
- R1: After reset the channel is idle, the interrupt is low, the start, end and command registers and the write counter are zero, and the readback pointer is 1, so the first data read returns bits 15:8 of the start address.
- R2: In 16-bit and 18-bit modes, each data write sets start = ((start<<8) | (end>>8)) and end = ((end<<8) | byte), both cut to 16 bits. Only the first 4 writes after a halt are accepted, and later writes leave both registers unchanged.
- R3: In 20-bit mode, 6 writes are accepted. Writes 1 to 5 shift end[15:8] into the low byte of start and set end = {end[7:0], byte}. Write 6 sets end = (end<<8) | byte. All values are cut to 20 bits, so six bytes b1..b6 give start = {b1[3:0],b2,b3} and end = {b4[3:0],b5,b6}.
- R4: A data read returns byte N of the start address, where N is the readback pointer (byte 0 = bits 7:0, byte 2 = bits 23:16 zero-extended). The pointer then counts down. From 0 it wraps to 2 when command bit 6 (extended readback) is held in 20-bit mode, and to 1 otherwise.
- R5: In 16-bit and 18-bit modes, command bits 6 (extended readback) and 2 (own status) are treated as zero.
- R6: In 18-bit mode, command bits 1:0 become address bits 17:16 of both start and end on a start command. In the other modes these bits have no effect.
- R7: A start command is a command with bit 4 set and bit 3 clear, and it keeps only bits 5 and 4. If 4 or fewer address bytes were written, both addresses are cut to 16 bits and the bank is added. Start bit 0 is then cleared. If end <= start, end is ORed with all ones of the mode's width: 16 bits, or 20 bits in 20-bit mode.
- R8: While running, each cycle in which the device requests and memory is ready moves one byte at the start address. Command bit 5 set means memory to device (mem_we_o low); bit 5 clear means device to memory. A beat that is not the last one increments the start address, and a cycle in which memory is not ready changes nothing.
- R9: The beat at start >= end is the last one. After it the interrupt is high, the channel is idle, the direction bit is cleared and the start register holds the last address moved.
- R10: A halt command (bit 3 set) wins over bit 4. It keeps only bits 6 and 2, stops the channel, clears the interrupt, resets the write counter and resets the readback pointer to its wrap value.
- R11: A status read returns 0x08 while the channel runs. When idle it returns 0x00 if own status (bit 2) is held, or else the device status with bit 3 cleared.
- R12: dev_block_o is high exactly while the channel runs.
- R13: A command or data write in the same cycle as a device request withholds the memory beat (mem_valid_o low, no ack). Data and status reads do not withhold it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Addressing mode: 0 = 16-bit, 1 = 18-bit banked, 2 = 20-bit extended |
| io_cmd_wr | input | 1 | Command write strobe |
| io_data_wr | input | 1 | Address byte write strobe |
| io_data_rd | input | 1 | Address byte read strobe |
| io_stat_rd | input | 1 | Status read strobe |
| io_wdata | input | 8 | Byte written by the processor |
| io_rdata | output | 8 | Status while io_stat_rd is high, else the readback byte |
| dev_status_i | input | 8 | Status byte of the attached device |
| dev_req_i | input | 1 | Device requests a byte transfer |
| dev_wdata_i | input | 8 | Byte from the device, for device-to-memory moves |
| dev_ack_o | output | 1 | Beat completed in this cycle |
| dev_rdata_o | output | 8 | Byte from memory, for memory-to-device moves |
| mem_valid_o | output | 1 | Memory beat request |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_we_o | output | 1 | Beat writes memory |
| mem_addr_o | output | 20 | Beat address |
| mem_wdata_o | output | 8 | Byte written to memory |
| mem_rdata_i | input | 8 | Byte read from memory |
| irq_o | output | 1 | End-of-transfer interrupt |
| dev_block_o | output | 1 | Direct processor access to the device is refused |

## Verification
Two functions can fall in the same cycle: the final memory beat, and a processor status read or command write. The bench holds a device request at the last address while it also pulses the status strobe. The status must still read busy in that cycle, and it must read the device status after the edge that raises the interrupt. The bench also drives a command write that has neither start nor halt set while a request is pending. It expects the beat to be withheld, and then expects the next beat to hit the same address.

// File: rtl/selch_pkg.sv
// Package: shared encodings for the selector channel.
// Assumes: command bit positions are fixed by the processor's software.
package selch_pkg;

    typedef enum logic [1:0] {
        MODE_16 = 2'd0,
        MODE_18 = 2'd1,
        MODE_20 = 2'd2,
        MODE_RSV = 2'd3
    } amode_e;

    localparam int CB_EXT  = 6;
    localparam int CB_DIR  = 5;
    localparam int CB_GO   = 4;
    localparam int CB_STOP = 3;
    localparam int CB_OWN  = 2;

    localparam logic [7:0] ST_BUSY = 8'h08;

    typedef struct packed {
        logic ext_rb;
        logic dir_rd;
        logic go;
        logic own_st;
    } ctl_t;

endpackage

// File: rtl/selch_cmd_ctrl.sv
// Module: command register, interrupt flag and status byte.
// Assumes: last_beat is never high in a cycle with a command write,
// because the transfer path withholds beats during processor writes.
module selch_cmd_ctrl
    import selch_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              cmd_wr,
    input  logic [6:0]        cmd_byte,
    input  logic              last_beat,
    input  logic [7:0]        dev_status,
    output ctl_t              ctl,
    output logic              stop_ev,
    output logic              stop_ext,
    output logic              go_ev,
    output logic [BANK_W-1:0] bank,
    output logic              irq,
    output logic [7:0]        status
);

    logic [6:0] masked;

    // Purpose: drop extended functions in narrow modes and decode the command.
    always_comb begin
        masked = cmd_byte;
        if (mode != MODE_20) begin
            masked[CB_EXT] = 1'b0;
            masked[CB_OWN] = 1'b0;
        end
        bank     = (mode == MODE_18) ? masked[BANK_W-1:0] : '0;
        stop_ev  = cmd_wr && masked[CB_STOP];
        go_ev    = cmd_wr && !masked[CB_STOP] && masked[CB_GO];
        stop_ext = masked[CB_EXT];
    end

    // Purpose: hold the command bits and the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
            irq <= 1'b0;
        end else if (stop_ev) begin
            ctl <= '{ext_rb: masked[CB_EXT], dir_rd: 1'b0, go: 1'b0,
                     own_st: masked[CB_OWN]};
            irq <= 1'b0;
        end else if (go_ev) begin
            ctl <= '{ext_rb: 1'b0, dir_rd: masked[CB_DIR], go: 1'b1,
                     own_st: 1'b0};
        end else if (last_beat) begin
            ctl.go     <= 1'b0;
            ctl.dir_rd <= 1'b0;
            irq        <= 1'b1;
        end
    end

    // Purpose: form the status byte seen by the processor.
    always_comb begin
        if (ctl.go)          status = ST_BUSY;
        else if (ctl.own_st) status = 8'h00;
        else                 status = dev_status & ~ST_BUSY;
    end

    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (!ctl.go && !irq));

    a_r9_last_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |=> (irq && !ctl.go && !ctl.dir_rd));

    a_r5_narrow_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && mode != MODE_20) |=> (!ctl.ext_rb && !ctl.own_st));

endmodule

// File: rtl/selch_addr_regs.sv
// Module: start/end address registers, write sequencer and readback pointer.
// Assumes: beat only arrives while the channel runs and never in a cycle
// with a processor write; ADDR_W > NARROW_W + BANK_W - 1 and ADDR_W <= 24.
module selch_addr_regs
    import selch_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int NARROW_W     = 16,
    parameter int BANK_W       = 2,
    parameter int NARROW_BYTES = 4,
    parameter int WIDE_BYTES   = 6,
    localparam int CNT_W       = $clog2(WIDE_BYTES + 1),
    localparam int PAD_W       = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [7:0]        wdata,
    input  logic              ext_rb,
    input  logic              stop_ev,
    input  logic              stop_ext,
    input  logic              go_ev,
    input  logic [BANK_W-1:0] bank,
    input  logic              beat,
    output logic [ADDR_W-1:0] start_addr,
    output logic              last,
    output logic [7:0]        rd_byte
);

    localparam logic [ADDR_W-1:0] NMASK = ADDR_W'((1 << NARROW_W) - 1);
    localparam logic [ADDR_W-1:0] WMASK = '1;

    logic [ADDR_W-1:0] end_addr;
    logic [CNT_W-1:0]  wcnt;
    logic [1:0]        rdp;
    logic              wide;
    logic [CNT_W-1:0]  limit;
    logic [ADDR_W-1:0] ld_start, ld_end;
    logic [ADDR_W-1:0] go_s0, go_e0, go_s1, go_e1;
    logic [1:0]        wrap_now, wrap_stop;
    logic [PAD_W-1:0]  padded;

    assign wide  = (mode == MODE_20);
    assign limit = wide ? CNT_W'(WIDE_BYTES) : CNT_W'(NARROW_BYTES);
    assign last  = (start_addr >= end_addr);

    // Purpose: next start/end values for one accepted address byte.
    always_comb begin
        if (!wide) begin
            ld_start = ((start_addr << 8) | (end_addr >> 8)) & NMASK;
            ld_end   = ((end_addr << 8) | ADDR_W'(wdata)) & NMASK;
        end else if (wcnt != CNT_W'(WIDE_BYTES - 1)) begin
            ld_start = (start_addr << 8) | ADDR_W'(end_addr[15:8]);
            ld_end   = ADDR_W'({end_addr[7:0], wdata});
        end else begin
            ld_start = start_addr;
            ld_end   = (end_addr << 8) | ADDR_W'(wdata);
        end
    end

    // Purpose: address adjustment applied by a start command.
    always_comb begin
        go_s0 = start_addr;
        go_e0 = end_addr;
        if (wcnt <= CNT_W'(NARROW_BYTES)) begin
            go_s0 = (start_addr & NMASK) | (ADDR_W'(bank) << NARROW_W);
            go_e0 = (end_addr & NMASK) | (ADDR_W'(bank) << NARROW_W);
        end
        go_s1 = go_s0 & ~ADDR_W'(1);
        go_e1 = go_e0;
        if (go_e0 <= go_s1)
            go_e1 = go_e0 | (wide ? WMASK : NMASK);
    end

    // Purpose: load, adjust and advance the address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_addr <= '0;
            end_addr   <= '0;
            wcnt       <= '0;
        end else if (stop_ev) begin
            wcnt <= '0;
        end else if (go_ev) begin
            start_addr <= go_s1;
            end_addr   <= go_e1;
        end else if (data_wr) begin
            if (wcnt < limit) begin
                start_addr <= ld_start;
                end_addr   <= ld_end;
                wcnt       <= wcnt + 1'b1;
            end
        end else if (beat && !last) begin
            start_addr <= start_addr + 1'b1;
        end
    end

    assign wrap_now  = (ext_rb && wide) ? 2'd2 : 2'd1;
    assign wrap_stop = (stop_ext && wide) ? 2'd2 : 2'd1;
    assign padded    = PAD_W'(start_addr);
    assign rd_byte   = 8'(padded >> {rdp, 3'b000});

    // Purpose: step the readback pointer on reads, reinit it on halt.
    always_ff @(posedge clk) begin
        if (!rst_n)          rdp <= 2'd1;
        else if (stop_ev)    rdp <= wrap_stop;
        else if (data_rd)    rdp <= (rdp == 2'd0) ? wrap_now : rdp - 1'b1;
    end

    a_r2_wcnt_limit: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= CNT_W'(WIDE_BYTES));

    a_r4_rdp_range: assert property (@(posedge clk) disable iff (!rst_n)
        rdp != 2'd3);

    a_r7_start_even: assert property (@(posedge clk) disable iff (!rst_n)
        go_ev |=> !start_addr[0]);

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !last) |=> (start_addr == $past(start_addr) + 1'b1));

    a_r9_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && last) |=> $stable(start_addr));

endmodule

// File: rtl/selch_xfer.sv
// Module: beat gating between the device stream and the memory port.
// Assumes: memory decides mem_ready_i in the same cycle; device holds
// dev_req_i until dev_ack_o.
module selch_xfer #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              dir_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              dev_req,
    input  logic [7:0]        dev_wdata,
    output logic              dev_ack,
    output logic [7:0]        dev_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              beat
);

    // Purpose: raise a beat for a device request unless the processor writes.
    always_comb begin
        mem_valid = go && dev_req && !cpu_wr;
        beat      = mem_valid && mem_ready;
        dev_ack   = beat;
        mem_we    = !dir_rd;
        mem_addr  = start_addr;
        mem_wdata = dev_wdata;
        dev_rdata = mem_rdata;
    end

    a_r13_no_beat_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> !mem_valid);

    a_r12_beat_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> go);

endmodule

// File: rtl/selch_dma.sv
// Module: top of the single-channel selector DMA controller.
// Assumes: mode_i is static while the channel runs.
module selch_dma
    import selch_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int NARROW_W     = 16,
    parameter int BANK_W       = 2,
    parameter int NARROW_BYTES = 4,
    parameter int WIDE_BYTES   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              io_cmd_wr,
    input  logic              io_data_wr,
    input  logic              io_data_rd,
    input  logic              io_stat_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [7:0]        dev_status_i,
    input  logic              dev_req_i,
    input  logic [7:0]        dev_wdata_i,
    output logic              dev_ack_o,
    output logic [7:0]        dev_rdata_o,
    output logic              mem_valid_o,
    input  logic              mem_ready_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              irq_o,
    output logic              dev_block_o
);

    ctl_t              ctl;
    logic              stop_ev, stop_ext, go_ev, irq, last, beat;
    logic [BANK_W-1:0] bank;
    logic [7:0]        status, rd_byte;
    logic [ADDR_W-1:0] start_addr;

    selch_cmd_ctrl #(.BANK_W(BANK_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .mode(mode_i),
        .cmd_wr(io_cmd_wr), .cmd_byte(io_wdata[6:0]),
        .last_beat(beat && last), .dev_status(dev_status_i),
        .ctl(ctl), .stop_ev(stop_ev), .stop_ext(stop_ext), .go_ev(go_ev),
        .bank(bank), .irq(irq), .status(status)
    );

    selch_addr_regs #(
        .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .BANK_W(BANK_W),
        .NARROW_BYTES(NARROW_BYTES), .WIDE_BYTES(WIDE_BYTES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .mode(mode_i),
        .data_wr(io_data_wr), .data_rd(io_data_rd), .wdata(io_wdata),
        .ext_rb(ctl.ext_rb), .stop_ev(stop_ev), .stop_ext(stop_ext),
        .go_ev(go_ev), .bank(bank), .beat(beat),
        .start_addr(start_addr), .last(last), .rd_byte(rd_byte)
    );

    selch_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .go(ctl.go), .dir_rd(ctl.dir_rd),
        .cpu_wr(io_cmd_wr || io_data_wr), .start_addr(start_addr),
        .dev_req(dev_req_i), .dev_wdata(dev_wdata_i),
        .dev_ack(dev_ack_o), .dev_rdata(dev_rdata_o),
        .mem_valid(mem_valid_o), .mem_ready(mem_ready_i), .mem_we(mem_we_o),
        .mem_addr(mem_addr_o), .mem_wdata(mem_wdata_o),
        .mem_rdata(mem_rdata_i), .beat(beat)
    );

    // Purpose: drive the processor read byte and the channel flags.
    always_comb begin
        io_rdata    = io_stat_rd ? status : rd_byte;
        irq_o       = irq;
        dev_block_o = ctl.go;
    end

    a_r12_block_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (io_stat_rd && io_rdata == ST_BUSY && !dev_status_i[3]) |-> dev_block_o);

endmodule

// File: tb/tb_selch_dma.sv
module tb_selch_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        io_cmd_wr = 1'b0, io_data_wr = 1'b0;
    logic        io_data_rd = 1'b0, io_stat_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [7:0]  dev_status_i = 8'h3C;
    logic        dev_req_i = 1'b0;
    logic [7:0]  dev_wdata_i = 8'h00;
    logic        dev_ack_o;
    logic [7:0]  dev_rdata_o;
    logic        mem_valid_o;
    logic        mem_ready_i = 1'b1;
    logic        mem_we_o;
    logic [19:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic        irq_o, dev_block_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mfun(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata_i = mfun(mem_addr_o);

    selch_dma dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .io_cmd_wr(io_cmd_wr), .io_data_wr(io_data_wr),
        .io_data_rd(io_data_rd), .io_stat_rd(io_stat_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_status_i(dev_status_i), .dev_req_i(dev_req_i),
        .dev_wdata_i(dev_wdata_i), .dev_ack_o(dev_ack_o),
        .dev_rdata_o(dev_rdata_o), .mem_valid_o(mem_valid_o),
        .mem_ready_i(mem_ready_i), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .irq_o(irq_o), .dev_block_o(dev_block_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start just after a falling edge and end at one.
    task automatic cmd(input logic [7:0] b);
        io_cmd_wr = 1'b1; io_wdata = b;
        @(negedge clk); io_cmd_wr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        io_data_wr = 1'b1; io_wdata = b;
        @(negedge clk); io_data_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] exp);
        io_data_rd = 1'b1; #1;
        chk(req, io_rdata, exp);
        @(negedge clk); io_data_rd = 1'b0;
    endtask

    task automatic st(input string req, input logic [7:0] exp);
        io_stat_rd = 1'b1; #1;
        chk(req, io_rdata, exp);
        @(negedge clk); io_stat_rd = 1'b0;
    endtask

    task automatic beat(input string req, input logic [19:0] addr,
                        input logic we, input logic [7:0] wd);
        dev_req_i = 1'b1; dev_wdata_i = wd; #1;
        chk({req, " valid"}, mem_valid_o, 1'b1);
        chk({req, " addr"}, mem_addr_o, addr);
        chk({req, " we"}, mem_we_o, we);
        chk({req, " ack"}, dev_ack_o, 1'b1);
        if (we) chk({req, " wdata"}, mem_wdata_o, wd);
        else    chk({req, " rdata"}, dev_rdata_o, mfun(addr));
        @(negedge clk); dev_req_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 irq", irq_o, 1'b0);
        chk("R1 R12 block", dev_block_o, 1'b0);
        st("R1 R11 status", 8'h34);
        wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        rd("R1 first read", 8'h11);
        rd("R4 ptr 0", 8'h22);
        rd("R4 wrap to 1", 8'h11);
    endtask

    task automatic t_narrow;
        mode_i = 2'd0;
        cmd(8'h08);
        wr(8'hA1); wr(8'hB2); wr(8'hC3); wr(8'hD4); wr(8'hE5);
        rd("R2 start hi", 8'hA1);
        rd("R2 start lo, 5th ignored", 8'hB2);
    endtask

    task automatic t_ext;
        mode_i = 2'd2;
        cmd(8'h48);
        wr(8'h01); wr(8'h23); wr(8'h45); wr(8'h06); wr(8'h78); wr(8'h9A);
        wr(8'hFF);
        rd("R3 R4 byte2", 8'h01);
        rd("R3 byte1", 8'h23);
        rd("R3 byte0", 8'h45);
        rd("R4 wrap to 2", 8'h01);
        cmd(8'h10);
        beat("R3 wide addr kept", 20'h12344, 1'b1, 8'h77);
        cmd(8'h08);
        chk("R10 halt idle", dev_block_o, 1'b0);
    endtask

    task automatic t_mask;
        mode_i = 2'd0;
        cmd(8'h0C);
        st("R5 own status dropped", 8'h34);
        mode_i = 2'd2;
        cmd(8'h0C);
        st("R11 own status zero", 8'h00);
        mode_i = 2'd0;
        cmd(8'h48);
        wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        rd("R5 ext ignored ptr1", 8'h11);
        rd("R5 ptr0", 8'h22);
        rd("R5 wrap to 1", 8'h11);
    endtask

    task automatic t_go_read;
        mode_i = 2'd0;
        cmd(8'h08);
        wr(8'h10); wr(8'h01); wr(8'h10); wr(8'h03);
        cmd(8'h33);
        chk("R12 block on", dev_block_o, 1'b1);
        st("R11 busy", 8'h08);
        beat("R6 R7 R8 first", 20'h01000, 1'b0, 8'h00);
        beat("R8 second", 20'h01001, 1'b0, 8'h00);
        dev_req_i = 1'b1; mem_ready_i = 1'b0; #1;
        chk("R8 stall ack", dev_ack_o, 1'b0);
        @(negedge clk); mem_ready_i = 1'b1;
        io_cmd_wr = 1'b1; io_wdata = 8'h00; #1;
        chk("R13 withheld valid", mem_valid_o, 1'b0);
        chk("R13 withheld ack", dev_ack_o, 1'b0);
        @(negedge clk); io_cmd_wr = 1'b0; dev_req_i = 1'b0;
        beat("R8 R13 same addr", 20'h01002, 1'b0, 8'h00);
        dev_req_i = 1'b1; io_stat_rd = 1'b1; #1;
        chk("R11 R13 busy at last beat", io_rdata, 8'h08);
        chk("R13 last ack", dev_ack_o, 1'b1);
        chk("R9 last addr", mem_addr_o, 20'h01003);
        @(negedge clk); dev_req_i = 1'b0; io_stat_rd = 1'b0;
        chk("R9 irq", irq_o, 1'b1);
        chk("R9 R12 block off", dev_block_o, 1'b0);
        st("R9 R11 idle status", 8'h34);
        rd("R9 start hi", 8'h10);
        rd("R9 start kept last", 8'h03);
        cmd(8'h08);
        chk("R10 irq clear", irq_o, 1'b0);
    endtask

    task automatic t_bank;
        mode_i = 2'd1;
        cmd(8'h08);
        wr(8'h00); wr(8'h20); wr(8'h00); wr(8'h21);
        cmd(8'h12);
        beat("R6 R8 bank write", 20'h20020, 1'b1, 8'hC3);
        beat("R6 R9 bank last", 20'h20021, 1'b1, 8'h3C);
        chk("R9 irq bank", irq_o, 1'b1);
        cmd(8'h08);
    endtask

    task automatic t_wrap;
        mode_i = 2'd0;
        cmd(8'h08);
        wr(8'hFF); wr(8'hFE); wr(8'hFF); wr(8'hFE);
        cmd(8'h10);
        beat("R7 wrap first", 20'h0FFFE, 1'b1, 8'h01);
        chk("R7 not end yet", irq_o, 1'b0);
        beat("R7 wrap top", 20'h0FFFF, 1'b1, 8'h02);
        chk("R7 end at top", irq_o, 1'b1);
        cmd(8'h08);
    endtask

    task automatic t_stop_mid;
        mode_i = 2'd0;
        cmd(8'h08);
        wr(8'h30); wr(8'h00); wr(8'h30); wr(8'h10);
        cmd(8'h30);
        beat("R8 pre-halt", 20'h03000, 1'b0, 8'h00);
        cmd(8'h18);
        chk("R10 halt wins over start", dev_block_o, 1'b0);
        chk("R10 no irq", irq_o, 1'b0);
        dev_req_i = 1'b1; #1;
        chk("R10 no beat after halt", mem_valid_o, 1'b0);
        @(negedge clk); dev_req_i = 1'b0;
        rd("R10 ptr reset", 8'h30);
        rd("R10 ptr 0", 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_narrow();
        t_ext();
        t_mask();
        t_go_read();
        t_bank();
        t_wrap();
        t_stop_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule